// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a stereo serial data stream into left and right 24-bit two's-complement words. It is a slave: the block clock is the incoming bit clock, and the serial input and the frame clock are sampled on each rising edge. A 3-bit format select sets the framing: 24-bit words aligned to the start of the half frame (MSB-justified), the same words delayed by one bit with the frame polarity inverted (I2S), or 16-, 20- or 24-bit words aligned to the end of the half frame (LSB-justified).

A small state machine controls decoding. Its states are `ST_SYNC`, `ST_COLLECT`, `ST_WAIT` and `ST_SHIFT`. Reset and any change of the format select force `ST_SYNC`. There the machine waits for a frame edge and moves to `ST_COLLECT` (start-aligned formats) or to `ST_SHIFT` (end-aligned formats).

- `ST_COLLECT` counts bit slots from the edge. It moves to `ST_WAIT` when the 24th bit is stored. If a frame edge arrives first, it emits the short word zero-filled and starts the next word.
- `ST_WAIT` ignores the remaining bits and returns to `ST_COLLECT` at the next edge.
- `ST_SHIFT` keeps a 32-bit history of the serial input. At every frame edge it emits the newest N bits, sign-extended.

Each word comes out with a one-cycle strobe for its channel. The data is held until that channel's next strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted, both output words are zero and both strobes are low.
- R2: Format codes 2, 5, 6 and 7 are start-aligned. The bit sampled on the rising edge where the frame clock first shows its new level is the MSB, and the next 23 samples follow MSB first. Bits after the 24th in a half frame are ignored.
- R3: Format code 3 is I2S. The MSB is the bit sampled one rising edge after the frame clock changes level, and frame clock low marks the left channel. With exactly 24 bit slots per half, the LSB is sampled on the first rising edge of the following half.
- R4: Format code 0 takes the last 16 bits sampled before each frame-clock transition as the word. It sign-extends bit 15 into bits 23..16 and ignores any earlier bits of the half frame.
- R5: Format code 1 takes the last 20 bits before each transition and sign-extends bit 19.
- R6: Format code 4 takes the last 24 bits before each transition.
- R7: In every format except code 3, frame clock high marks the left channel.
- R8: Each strobe is high for exactly one cycle, and the left and right strobes are never high together. In start-aligned formats a word's strobe appears in the cycle after its 24th bit is sampled. In end-aligned formats it appears in the cycle after the first sample of the new frame-clock level. Output data changes only with its strobe.
- R9: In start-aligned and I2S formats, a half frame that ends before 24 bits arrive is emitted at the following frame edge, with the missing low bits set to zero.
- R10: Format codes 5, 6 and 7 decode exactly as code 2.
- R11: After reset, and after any change of the format select, the half frame in progress is discarded. No strobe is produced for a half frame whose opening edge was not observed in the current format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_clk | input | 1 | Frame clock marking the channel halves |
| sdata | input | 1 | Serial audio data, MSB first |
| fmt_sel | input | 3 | Framing format code |
| left_word | output | WORD_W | Last left-channel word, sign-extended |
| left_valid | output | 1 | One-cycle strobe for a new left word |
| right_word | output | WORD_W | Last right-channel word, sign-extended |
| right_valid | output | 1 | One-cycle strobe for a new right word |

## Verification
The bench drives halves longer than the word in the end-aligned formats. A receiver that counted from the start of the half would then return the leading filler instead of the word, and one that skipped sign extension would show wrong upper bits. In I2S it uses exactly 24-slot halves, so the LSB falls past the frame edge; a receiver that ended the word at the edge would lose that bit or put the word on the wrong channel. Short start-aligned halves check the zero fill, and the cycle of each strobe is compared exactly to catch an off-by-one in slot counting. Every format change is followed by a partial half frame, which a receiver without resynchronisation would emit as a spurious word.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;

    typedef enum logic [1:0] {
        ST_SYNC    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_WAIT    = 2'd2,
        ST_SHIFT   = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic       lsb_mode;
        logic       i2s_mode;
        logic [5:0] lsb_len;
    } fmt_cfg_t;

    function automatic fmt_cfg_t decode_fmt(input logic [2:0] code);
        fmt_cfg_t c;
        c.lsb_mode = 1'b0;
        c.i2s_mode = 1'b0;
        c.lsb_len  = 6'd24;
        case (code)
            3'd0: begin c.lsb_mode = 1'b1; c.lsb_len = 6'd16; end
            3'd1: begin c.lsb_mode = 1'b1; c.lsb_len = 6'd20; end
            3'd3: c.i2s_mode = 1'b1;
            3'd4: begin c.lsb_mode = 1'b1; c.lsb_len = 6'd24; end
            default: c.lsb_mode = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sar_frame_edge.sv
`timescale 1ns/1ps
module sar_frame_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_clk,
    input  logic i2s_mode,
    output logic eff_now,
    output logic eff_prev,
    output logic frame_edge
);
    logic fc_d1;
    logic fc_d2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fc_d1 <= 1'b0;
            fc_d2 <= 1'b0;
        end else begin
            fc_d1 <= frame_clk;
            fc_d2 <= fc_d1;
        end
    end

    // I2S: the frame boundary is moved one slot late and inverted so that
    // high always means left and the MSB always sits on the effective edge.
    assign eff_now    = i2s_mode ? ~fc_d1 : frame_clk;
    assign eff_prev   = i2s_mode ? ~fc_d2 : fc_d1;
    assign frame_edge = eff_now ^ eff_prev;
endmodule

// File: rtl/sar_lsb_shift.sv
`timescale 1ns/1ps
module sar_lsb_shift #(
    parameter int SHIFT_W = 32,
    parameter int WORD_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata,
    input  logic [5:0]        len,
    output logic [WORD_W-1:0] word_ext
);
    localparam int IDX_W = $clog2(SHIFT_W);

    logic [SHIFT_W-1:0] sh_q;
    logic [IDX_W-1:0]   sign_idx;
    logic               sign_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SHIFT_W-2:0], sdata};
    end

    assign sign_idx = IDX_W'(len - 6'd1);
    assign sign_bit = sh_q[sign_idx];

    // The history excludes the bit sampled this cycle, so at a frame edge
    // it holds exactly the closing half frame.
    for (genvar gi = 0; gi < WORD_W; gi++) begin : g_ext
        if (gi < SHIFT_W) begin : g_in
            assign word_ext[gi] = (6'(gi) < len) ? sh_q[gi] : sign_bit;
        end else begin : g_sign
            assign word_ext[gi] = sign_bit;
        end
    end
endmodule

// File: rtl/sar_msb_accum.sv
`timescale 1ns/1ps
module sar_msb_accum #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata,
    input  logic              start,
    input  logic              take,
    output logic [WORD_W-1:0] held_word,
    output logic [WORD_W-1:0] merged_word,
    output logic              at_last
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] acc_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] top_bit;
    logic [WORD_W-1:0] bit_vec;

    assign top_bit     = {sdata, {(WORD_W-1){1'b0}}};
    assign bit_vec     = top_bit >> cnt_q;
    assign merged_word = acc_q | bit_vec;
    assign held_word   = acc_q;
    assign at_last     = (cnt_q == CNT_W'(WORD_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (start) begin
            acc_q <= top_bit;
            cnt_q <= CNT_W'(1);
        end else if (take) begin
            acc_q <= merged_word;
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/serial_audio_rx.sv
`timescale 1ns/1ps
module serial_audio_rx #(
    parameter int WORD_W  = 24,
    parameter int SHIFT_W = 32
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              frame_clk,
    input  logic              sdata,
    input  logic [2:0]        fmt_sel,
    output logic [WORD_W-1:0] left_word,
    output logic              left_valid,
    output logic [WORD_W-1:0] right_word,
    output logic              right_valid
);
    import sar_pkg::*;

    fmt_cfg_t          cfg;
    logic [2:0]        fmt_q;
    rx_state_e         state_q;
    rx_state_e         state_d;
    logic              eff_now;
    logic              eff_prev;
    logic              frame_edge;
    logic [WORD_W-1:0] lsb_word;
    logic [WORD_W-1:0] held_word;
    logic [WORD_W-1:0] merged_word;
    logic              at_last;
    logic              start;
    logic              take;
    logic              emit;
    logic              emit_left;
    logic [WORD_W-1:0] emit_word;
    logic              word_left_q;

    assign cfg = decode_fmt(fmt_sel);

    sar_frame_edge u_edge (
        .clk        (bclk),
        .rst_n      (rst_n),
        .frame_clk  (frame_clk),
        .i2s_mode   (cfg.i2s_mode),
        .eff_now    (eff_now),
        .eff_prev   (eff_prev),
        .frame_edge (frame_edge)
    );

    sar_lsb_shift #(.SHIFT_W(SHIFT_W), .WORD_W(WORD_W)) u_lsb (
        .clk      (bclk),
        .rst_n    (rst_n),
        .sdata    (sdata),
        .len      (cfg.lsb_len),
        .word_ext (lsb_word)
    );

    sar_msb_accum #(.WORD_W(WORD_W)) u_msb (
        .clk         (bclk),
        .rst_n       (rst_n),
        .sdata       (sdata),
        .start       (start),
        .take        (take),
        .held_word   (held_word),
        .merged_word (merged_word),
        .at_last     (at_last)
    );

    // State register
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SYNC;
        else        state_q <= state_d;
    end

    // Format tracking and channel of the word being collected
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q       <= 3'd0;
            word_left_q <= 1'b0;
        end else begin
            fmt_q <= fmt_sel;
            if (start) word_left_q <= eff_now;
        end
    end

    // Next state and word decisions
    always_comb begin
        state_d   = state_q;
        start     = 1'b0;
        take      = 1'b0;
        emit      = 1'b0;
        emit_left = 1'b0;
        emit_word = '0;
        if (fmt_sel != fmt_q) begin
            state_d = ST_SYNC;
        end else begin
            unique case (state_q)
                ST_SYNC: begin
                    if (frame_edge) begin
                        if (cfg.lsb_mode) begin
                            state_d = ST_SHIFT;
                        end else begin
                            start   = 1'b1;
                            state_d = ST_COLLECT;
                        end
                    end
                end
                ST_COLLECT: begin
                    if (frame_edge) begin
                        emit      = 1'b1;
                        emit_word = held_word;
                        emit_left = word_left_q;
                        start     = 1'b1;
                    end else begin
                        take = 1'b1;
                        if (at_last) begin
                            emit      = 1'b1;
                            emit_word = merged_word;
                            emit_left = word_left_q;
                            state_d   = ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (frame_edge) begin
                        start   = 1'b1;
                        state_d = ST_COLLECT;
                    end
                end
                ST_SHIFT: begin
                    if (frame_edge) begin
                        emit      = 1'b1;
                        emit_word = lsb_word;
                        emit_left = eff_prev;
                    end
                end
            endcase
        end
    end

    // Output registers
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            left_word   <= '0;
            right_word  <= '0;
            left_valid  <= 1'b0;
            right_valid <= 1'b0;
        end else begin
            left_valid  <= emit & emit_left;
            right_valid <= emit & ~emit_left;
            if (emit & emit_left)  left_word  <= emit_word;
            if (emit & ~emit_left) right_word <= emit_word;
        end
    end
endmodule

// File: rtl/sar_checker.sv
`timescale 1ns/1ps
module sar_checker #(
    parameter int WORD_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        fmt_sel,
    input logic              frame_clk,
    input logic              left_valid,
    input logic              right_valid,
    input logic [WORD_W-1:0] left_word,
    input logic [WORD_W-1:0] right_word
);
    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        !(left_valid && right_valid)); // R8

    AST_LEFT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        left_valid |=> !left_valid); // R8

    AST_RIGHT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        right_valid |=> !right_valid); // R8

    AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !left_valid |-> $stable(left_word)); // R8

    AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !right_valid |-> $stable(right_word)); // R8

    AST_SIGN_16: assert property (@(posedge clk) disable iff (!rst_n)
        (left_valid && $past(fmt_sel) == 3'd0) |->
            (left_word[WORD_W-1:15] == '0 || left_word[WORD_W-1:15] == '1)); // R4

    AST_SIGN_20: assert property (@(posedge clk) disable iff (!rst_n)
        (right_valid && $past(fmt_sel) == 3'd1) |->
            (right_word[WORD_W-1:19] == '0 || right_word[WORD_W-1:19] == '1)); // R5

    AST_LSB_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((left_valid || right_valid) && $past(fmt_sel) == 3'd4) |->
            ($past(frame_clk) != $past(frame_clk, 2))); // R6
endmodule

bind serial_audio_rx sar_checker #(.WORD_W(WORD_W)) u_sar_checker (
    .clk         (bclk),
    .rst_n       (rst_n),
    .fmt_sel     (fmt_sel),
    .frame_clk   (frame_clk),
    .left_valid  (left_valid),
    .right_valid (right_valid),
    .left_word   (left_word),
    .right_word  (right_word)
);

// File: tb/serial_audio_rx_bench.sv
`timescale 1ns/1ps
module serial_audio_rx_bench;
    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_clk = 1'b0;
    logic        sdata = 1'b0;
    logic [2:0]  fmt_sel = 3'd2;
    logic [23:0] left_word;
    logic        left_valid;
    logic [23:0] right_word;
    logic        right_valid;

    serial_audio_rx u_serial_audio_rx (
        .bclk        (bclk),
        .rst_n       (rst_n),
        .frame_clk   (frame_clk),
        .sdata       (sdata),
        .fmt_sel     (fmt_sel),
        .left_word   (left_word),
        .left_valid  (left_valid),
        .right_word  (right_word),
        .right_valid (right_valid)
    );

    always #2 bclk = ~bclk;

    int cyc = 0;
    always @(posedge bclk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [23:0] q_data[$];
    bit          q_left[$];
    int          q_cyc[$];
    string       q_req[$];

    int   cur_fmt = 2;
    bit   cur_lvl = 0;
    bit   pend_v = 0;
    logic pend_b = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic handle(input bit is_left, input logic [23:0] d);
        logic [23:0] ed;
        bit          el;
        int          ec;
        string       rq;
        if (q_data.size() == 0) begin
            check(0, "R11", "unexpected strobe", d, 0);
        end else begin
            ed = q_data.pop_front();
            el = q_left.pop_front();
            ec = q_cyc.pop_front();
            rq = q_req.pop_front();
            check(d == ed, rq, "word", d, ed);
            check(is_left == el, "R7", "channel", 32'(is_left), 32'(el));
            check(cyc == ec, "R8", "strobe cycle", cyc, ec);
        end
    endtask

    // Monitor: pops the scoreboard as strobes appear
    always @(negedge bclk) begin
        if (rst_n && !done) begin
            if (left_valid && right_valid)
                check(0, "R8", "both strobes", 1, 0);
            if (left_valid)  handle(1'b1, left_word);
            if (right_valid) handle(1'b0, right_word);
        end
    end

    // Driver: one half frame of hl slots at the given frame-clock level
    task automatic drive_half(input bit level, input logic [23:0] w,
                              input int hl, input bit keep);
        bit          lsb;
        bit          i2s;
        int          n;
        int          k;
        int          d0;
        logic [23:0] exp;
        logic        b;
        string       rq;
        lsb = (cur_fmt == 0) || (cur_fmt == 1) || (cur_fmt == 4);
        i2s = (cur_fmt == 3);
        n   = (cur_fmt == 0) ? 16 : (cur_fmt == 1) ? 20 : 24;
        for (int i = 0; i < hl; i++) begin
            @(negedge bclk);
            if (i == 0 && keep) begin
                d0 = cyc;
                if (lsb) begin
                    if (n == 16)      exp = {{8{w[15]}}, w[15:0]};
                    else if (n == 20) exp = {{4{w[19]}}, w[19:0]};
                    else              exp = w;
                    q_cyc.push_back(d0 + hl + 1);
                    rq = (n == 16) ? "R4" : (n == 20) ? "R5" : "R6";
                end else begin
                    k   = (hl < 24) ? hl : 24;
                    exp = w & ~(24'hFFFFFF >> k);
                    q_cyc.push_back(((hl >= 24) ? d0 + 24 : d0 + hl + 1) + (i2s ? 1 : 0));
                    if (hl < 24)     rq = "R9";
                    else if (i2s)    rq = "R3";
                    else if (cur_fmt > 4) rq = "R10";
                    else             rq = "R2";
                end
                q_data.push_back(exp);
                q_left.push_back(i2s ? ~level : level);
                q_req.push_back(rq);
            end
            frame_clk = level;
            b = 1'($urandom);
            if (lsb) begin
                if (i >= hl - n) b = w[n - 1 - (i - (hl - n))];
            end else if (i2s) begin
                if (i == 0) begin
                    if (pend_v) b = pend_b;
                end else if (i - 1 < 24) begin
                    b = w[23 - (i - 1)];
                end
            end else begin
                if (i < 24) b = w[23 - i];
            end
            sdata = b;
        end
        if (i2s) begin
            if (hl <= 24) begin
                pend_b = w[24 - hl];
                pend_v = 1;
            end else begin
                pend_v = 0;
            end
        end
    endtask

    // Segment: format change inside a partial half, four halves, short closer
    task automatic segment(input int f, input int h0, input int h1,
                           input int h2, input int h3);
        for (int i = 0; i < 20; i++) begin
            @(negedge bclk);
            if (i == 0) begin
                fmt_sel = 3'(f);
                cur_fmt = f;
                pend_v  = 0;
            end
            frame_clk = cur_lvl;
            sdata     = 1'($urandom);
        end
        cur_lvl = ~cur_lvl; drive_half(cur_lvl, 24'($urandom), h0, 1);
        cur_lvl = ~cur_lvl; drive_half(cur_lvl, 24'($urandom), h1, 1);
        cur_lvl = ~cur_lvl; drive_half(cur_lvl, 24'($urandom), h2, 1);
        cur_lvl = ~cur_lvl; drive_half(cur_lvl, 24'($urandom), h3, 1);
        cur_lvl = ~cur_lvl; drive_half(cur_lvl, 24'($urandom), 2, 0);
    endtask

    initial begin
        repeat (5) @(negedge bclk);
        check(left_word == 24'd0,  "R1", "left word in reset",  left_word, 0);
        check(right_word == 24'd0, "R1", "right word in reset", right_word, 0);
        check(!left_valid,  "R1", "left strobe in reset",  32'(left_valid), 0);
        check(!right_valid, "R1", "right strobe in reset", 32'(right_valid), 0);
        rst_n = 1'b1;
        segment(2, 32, 32, 24, 20);  // R2, R9
        segment(3, 24, 32, 24, 30);  // R3
        segment(0, 16, 32, 16, 20);  // R4
        segment(1, 20, 32, 24, 40);  // R5
        segment(4, 24, 32, 48, 24);  // R6
        segment(6, 32, 24, 32, 24);  // R10
        segment(3, 20, 24, 16, 28);  // R3, R9
        segment(7, 16, 40, 24, 12);  // R10, R9
        segment(5, 24, 24, 64, 24);  // R10
        segment(0, 32, 16, 64, 16);  // R4
        repeat (12) @(negedge bclk);
        check(q_data.size() == 0, "R11", "missing strobes", q_data.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule